// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Register File

This block keeps wall-clock time and a calendar in packed BCD and presents them, together with a handful of plain storage bytes, as sixteen byte-wide registers. A host reaches them through active-low chip-enable, write-enable and output-enable strobes, a 4-bit address and separate 8-bit write and read data buses. The block counts seconds, minutes, hours (24-hour form), a day of week, the date, the month, a two-digit year and a separate two-digit century. A one-cycle `osc_tick` enable, pulsed once per period of a 32.768 kHz oscillator, is divided down to a once-per-second advance.

Software never reads the counters directly. It reads a holding copy that follows the counters on every clock while both freeze bits in the control register are clear. Setting the read-freeze bit holds that copy still, so a multi-byte read sees one coherent instant while counting goes on underneath. Setting the write-freeze bit also holds the copy, and time writes then land in it. Clearing the write-freeze bit transfers the whole copy into the counters in one clock and restarts the sub-second divider. A stop bit in the seconds byte halts timekeeping.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, date 01, month 01, year 00, century 00; the control byte reads 00h.
- R2: Seconds and minutes count 00–59 and hours 00–23 in BCD. Each wrap to 00 carries into the next field.
- R3: Day of week (address Ch, bits 2:0) counts 1–7, wraps from 7 to 1, and advances when hours wrap.
- R4: The date (address Dh) wraps to 01 after the last day of the month. That is 30 for months 04, 06, 09 and 11, and 31 for other months. February ends on 28, or on 29 when the BCD year is a multiple of four.
- R5: Month (address Eh) wraps from 12 to 01 and carries into the year (address Fh). The year wraps from 99 to 00 and carries into the century (address 1h).
- R6: While seconds bit 7 (stop) is 1, no time field changes however many ticks arrive.
- R7: While control bit 6 (read freeze) is 1, reads of time registers return the values present when it was set. After it clears, reads return the current count.
- R8: While control bit 7 (write freeze) is 1, time writes go to the holding copy only. Writing control with bit 7 cleared loads every time field at once and restarts the divider, so the next second begins after a full TICKS_PER_SEC ticks.
- R9: Writes to time addresses (1h, 9h–Fh) while control bit 7 is 0 are ignored.
- R10: Bytes at 2h–8h store what is written, subject to R11. Writing them leaves the time unchanged. Control bits 5:0 have no timing effect.
- R11: Unused bits read 0. Address 0h always reads 00h. Masks are: 4h and 6h BFh, minutes 7Fh, hours 3Fh, day 47h (bit 6 is a stored test bit), date 3Fh, month 1Fh.
- R12: Seconds advance once per TICKS_PER_SEC `osc_tick` pulses.
- R13: `rdata` is 00h unless `ce_n`=0, `oe_n`=0 and `we_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write takes effect at the clock edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the holding copy and stored bytes |

## Verification
The assertions check the following on every cycle:
- the divider count stays in range and steps by one per tick;
- a load delivers exactly the holding copy;
- a set stop bit keeps every counter still;
- the minute wraps when a second step crosses 59:59;
- the holding copy stays still under either freeze bit.

Other behaviour can only be shown by the bench's scenarios. These cover calendar month lengths, the leap rule, century carry, ignored writes with write-freeze clear, read masks, and the restart of the divider after a load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       stop;
    logic       ft;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
    logic [7:0] cent;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{stop: 1'b0, ft: 1'b0, sec: 8'h00,
                                      min: 8'h00, hour: 8'h00, day: 8'h01,
                                      date: 8'h01, month: 8'h01,
                                      year: 8'h00, cent: 8'h00};

  localparam logic [3:0] A_FLAGS = 4'h0;
  localparam logic [3:0] A_CENT  = 4'h1;
  localparam logic [3:0] A_CTRL  = 4'h8;
  localparam logic [3:0] A_SEC   = 4'h9;
  localparam logic [3:0] A_MIN   = 4'hA;
  localparam logic [3:0] A_HOUR  = 4'hB;
  localparam logic [3:0] A_DAY   = 4'hC;
  localparam logic [3:0] A_DATE  = 4'hD;
  localparam logic [3:0] A_MONTH = 4'hE;
  localparam logic [3:0] A_YEAR  = 4'hF;

  localparam int MISC_LO = 2;
  localparam int MISC_HI = 7;

  // Next BCD value of a two-digit byte.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // {carry, next}: wraps to lo once v reaches hi.
  function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] hi,
                                          input logic [7:0] lo);
    if (v >= hi) return {1'b1, lo};
    else         return {1'b0, bcd_inc(v)};
  endfunction

  // Leap when the BCD year is a multiple of four.
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m,
                                            input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Write mask of the plain storage bytes at 2h..7h.
  function automatic logic [7:0] misc_mask(input logic [3:0] a);
    case (a)
      4'h4, 4'h6: return 8'hBF;
      default:    return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic clr,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = osc_tick && at_last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (osc_tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_tick_steps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !clr && !at_last) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_clear_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_pulse,
  input  logic      load_en,
  input  rtc_time_t load_val,
  output rtc_time_t live
);
  logic       step;
  logic [8:0] r_sec, r_min, r_hour, r_day, r_date, r_month, r_year, r_cent;
  logic       c_min, c_hour, c_day, c_month, c_year, c_cent;

  assign step    = sec_pulse && !live.stop && !load_en;
  assign r_sec   = bcd_step(live.sec,   8'h59, 8'h00);
  assign r_min   = bcd_step(live.min,   8'h59, 8'h00);
  assign r_hour  = bcd_step(live.hour,  8'h23, 8'h00);
  assign r_day   = bcd_step(live.day,   8'h07, 8'h01);
  assign r_date  = bcd_step(live.date,  month_days(live.month, live.year), 8'h01);
  assign r_month = bcd_step(live.month, 8'h12, 8'h01);
  assign r_year  = bcd_step(live.year,  8'h99, 8'h00);
  assign r_cent  = bcd_step(live.cent,  8'h99, 8'h00);

  assign c_min   = step    && r_sec[8];
  assign c_hour  = c_min   && r_min[8];
  assign c_day   = c_hour  && r_hour[8];
  assign c_month = c_day   && r_date[8];
  assign c_year  = c_month && r_month[8];
  assign c_cent  = c_year  && r_year[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= RTC_RESET;
    else if (load_en) live <= load_val;
    else begin
      if (step)    live.sec   <= r_sec[7:0];
      if (c_min)   live.min   <= r_min[7:0];
      if (c_hour)  live.hour  <= r_hour[7:0];
      if (c_day) begin
        live.day  <= r_day[7:0];
        live.date <= r_date[7:0];
      end
      if (c_month) live.month <= r_month[7:0];
      if (c_year)  live.year  <= r_year[7:0];
      if (c_cent)  live.cent  <= r_cent[7:0];
    end
  end

  p_load_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> live == $past(load_val));
  p_stop_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live.stop && !load_en) |=> $stable(live));
  p_min_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && live.sec == 8'h59 && live.min == 8'h59) |=> live.min == 8'h00);
endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int WBIT = 7;
  localparam int RBIT = 6;

  logic       wr_strobe, rd_en, load_en, sec_pulse, track;
  logic [7:0] ctrl_q, mux;
  logic [7:0] misc_q [MISC_LO:MISC_HI];
  rtc_time_t  live, hold;

  assign wr_strobe = !ce_n && !we_n;
  assign rd_en     = !ce_n && !oe_n && we_n;
  assign load_en   = wr_strobe && (addr == A_CTRL) && ctrl_q[WBIT] && !wdata[WBIT];
  assign track     = !ctrl_q[WBIT] && !ctrl_q[RBIT];

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .clr(load_en || live.stop), .sec_pulse(sec_pulse)
  );

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
    .load_en(load_en), .load_val(hold), .live(live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ctrl_q <= 8'h00;
    else if (wr_strobe && addr == A_CTRL)         ctrl_q <= wdata;
  end

  for (genvar g = MISC_LO; g <= MISC_HI; g++) begin : g_misc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) misc_q[g] <= 8'h00;
      else if (wr_strobe && addr == 4'(g))
        misc_q[g] <= wdata & misc_mask(4'(g));
    end
  end

  // Holding copy: follows the counters unless frozen; takes writes under write freeze.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= RTC_RESET;
    else if (track) hold <= live;
    else if (ctrl_q[WBIT] && wr_strobe) begin
      case (addr)
        A_CENT:  hold.cent  <= wdata;
        A_SEC: begin
          hold.stop <= wdata[7];
          hold.sec  <= wdata & 8'h7F;
        end
        A_MIN:   hold.min   <= wdata & 8'h7F;
        A_HOUR:  hold.hour  <= wdata & 8'h3F;
        A_DAY: begin
          hold.ft  <= wdata[6];
          hold.day <= wdata & 8'h07;
        end
        A_DATE:  hold.date  <= wdata & 8'h3F;
        A_MONTH: hold.month <= wdata & 8'h1F;
        A_YEAR:  hold.year  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    mux = 8'h00;
    for (int i = MISC_LO; i <= MISC_HI; i++)
      if (addr == 4'(i)) mux = misc_q[i];
    case (addr)
      A_FLAGS: mux = 8'h00;
      A_CENT:  mux = hold.cent;
      A_CTRL:  mux = ctrl_q;
      A_SEC:   mux = hold.sec | {hold.stop, 7'b0};
      A_MIN:   mux = hold.min;
      A_HOUR:  mux = hold.hour;
      A_DAY:   mux = hold.day | {1'b0, hold.ft, 6'b0};
      A_DATE:  mux = hold.date;
      A_MONTH: mux = hold.month;
      A_YEAR:  mux = hold.year;
      default: ;
    endcase
  end

  assign rdata = rd_en ? mux : 8'h00;

  p_read_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[RBIT] && !ctrl_q[WBIT]) |=> $stable(hold));
  p_write_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[WBIT] && !wr_strobe) |=> $stable(hold));
  p_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    track |=> hold == $past(live));
endmodule

// File: tb/tb_rtc_bcd_regfile.sv
module tb_rtc_bcd_regfile;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int         checks = 0;
  int         errs = 0;

  always #4 clk = ~clk;

  rtc_bcd_regfile #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] exp,
                            input string tag);
    logic [7:0] got;
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    #1 got = rdata;
    ce_n = 1; oe_n = 1;
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1;
      @(negedge clk); osc_tick = 0;
    end
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dy, dt, mo, y, c);
    wr(4'h8, 8'h80);
    wr(4'h9, s); wr(4'hA, mi); wr(4'hB, h); wr(4'hC, dy);
    wr(4'hD, dt); wr(4'hE, mo); wr(4'hF, y); wr(4'h1, c);
    wr(4'h8, 8'h00);
  endtask

  task automatic t_reset;
    expect_reg(4'h9, 8'h00, "R1 sec");
    expect_reg(4'hA, 8'h00, "R1 min");
    expect_reg(4'hB, 8'h00, "R1 hour");
    expect_reg(4'hC, 8'h01, "R1 day");
    expect_reg(4'hD, 8'h01, "R1 date");
    expect_reg(4'hE, 8'h01, "R1 month");
    expect_reg(4'hF, 8'h00, "R1 year");
    expect_reg(4'h1, 8'h00, "R1 century");
    expect_reg(4'h8, 8'h00, "R1 control");
  endtask

  task automatic t_clock_carries;
    set_time(8'h59, 8'h14, 8'h10, 8'h02, 8'h15, 8'h06, 8'h21, 8'h20);
    ticks(TPS);
    expect_reg(4'h9, 8'h00, "R2 sec wrap");
    expect_reg(4'hA, 8'h15, "R2 min carry");
    set_time(8'h59, 8'h59, 8'h10, 8'h02, 8'h15, 8'h06, 8'h21, 8'h20);
    ticks(TPS);
    expect_reg(4'hA, 8'h00, "R2 min wrap");
    expect_reg(4'hB, 8'h11, "R2 hour carry");
    expect_reg(4'hC, 8'h02, "R3 day kept mid-day");
  endtask

  task automatic t_year_end;
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h19);
    ticks(TPS);
    expect_reg(4'hB, 8'h00, "R2 hour wrap");
    expect_reg(4'hC, 8'h01, "R3 day 7 to 1");
    expect_reg(4'hD, 8'h01, "R4 date wrap dec");
    expect_reg(4'hE, 8'h01, "R5 month wrap");
    expect_reg(4'hF, 8'h00, "R5 year wrap");
    expect_reg(4'h1, 8'h20, "R5 century carry");
  endtask

  task automatic t_month_lengths;
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    ticks(TPS);
    expect_reg(4'hD, 8'h29, "R4 leap feb 29");
    expect_reg(4'hC, 8'h04, "R3 day advance");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20);
    ticks(TPS);
    expect_reg(4'hD, 8'h01, "R4 leap feb end");
    expect_reg(4'hE, 8'h03, "R4 leap to march");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23, 8'h20);
    ticks(TPS);
    expect_reg(4'hD, 8'h01, "R4 common feb end");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23, 8'h20);
    ticks(TPS);
    expect_reg(4'hE, 8'h05, "R4 april 30 end");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h20);
    ticks(TPS);
    expect_reg(4'hD, 8'h31, "R4 january 31");
  endtask

  task automatic t_stop;
    set_time(8'h85, 8'h30, 8'h08, 8'h01, 8'h10, 8'h03, 8'h22, 8'h20);
    ticks(2 * TPS);
    expect_reg(4'h9, 8'h85, "R6 stopped sec");
    expect_reg(4'hA, 8'h30, "R6 stopped min");
    set_time(8'h20, 8'h30, 8'h08, 8'h01, 8'h10, 8'h03, 8'h22, 8'h20);
    ticks(TPS);
    expect_reg(4'h9, 8'h21, "R6 resumed");
  endtask

  task automatic t_divider;
    set_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h10, 8'h03, 8'h22, 8'h20);
    ticks(TPS - 1);
    expect_reg(4'h9, 8'h00, "R12 before full second");
    ticks(1);
    expect_reg(4'h9, 8'h01, "R12 one second");
    ticks(2);
    wr(4'h8, 8'h80);
    wr(4'h9, 8'h30);
    ticks(TPS);
    expect_reg(4'h9, 8'h30, "R8 holding shows write");
    wr(4'h8, 8'h00);
    ticks(TPS - 1);
    expect_reg(4'h9, 8'h30, "R8 divider restarted");
    ticks(1);
    expect_reg(4'h9, 8'h31, "R8 full second after load");
  endtask

  task automatic t_read_freeze;
    set_time(8'h10, 8'h00, 8'h12, 8'h01, 8'h10, 8'h03, 8'h22, 8'h20);
    wr(4'h8, 8'h40);
    ticks(TPS);
    expect_reg(4'h9, 8'h10, "R7 frozen view");
    wr(4'h8, 8'h00);
    expect_reg(4'h9, 8'h11, "R7 view resumes");
  endtask

  task automatic t_ignored_and_misc;
    wr(4'h9, 8'h45);
    wr(4'hB, 8'h05);
    wr(4'h1, 8'h77);
    expect_reg(4'h9, 8'h11, "R9 sec write ignored");
    expect_reg(4'hB, 8'h12, "R9 hour write ignored");
    expect_reg(4'h1, 8'h20, "R9 century write ignored");
    wr(4'h7, 8'hFF);
    expect_reg(4'h7, 8'hFF, "R10 byte 7h");
    wr(4'h2, 8'h5A);
    expect_reg(4'h2, 8'h5A, "R10 byte 2h");
    wr(4'h8, 8'h3F);
    expect_reg(4'h8, 8'h3F, "R10 control stored");
    expect_reg(4'h9, 8'h11, "R10 time undisturbed");
    ticks(TPS);
    expect_reg(4'h9, 8'h12, "R10 calibration no effect");
    wr(4'h8, 8'h00);
    wr(4'h0, 8'hFF);
    expect_reg(4'h0, 8'h00, "R11 address 0h");
    wr(4'h6, 8'hFF);
    expect_reg(4'h6, 8'hBF, "R11 mask 6h");
    wr(4'h4, 8'hFF);
    expect_reg(4'h4, 8'hBF, "R11 mask 4h");
    set_time(8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h3F, 8'hFF, 8'h22, 8'h20);
    wr(4'h8, 8'h40);
    expect_reg(4'hC, 8'h47, "R11 day mask");
    expect_reg(4'hA, 8'h7F, "R11 minute mask");
    expect_reg(4'hB, 8'h3F, "R11 hour mask");
    expect_reg(4'hE, 8'h1F, "R11 month mask");
    wr(4'h8, 8'h00);
  endtask

  task automatic t_read_gate;
    logic [7:0] got;
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = 4'h7;
    #1 got = rdata;
    checks++;
    if (got !== 8'h00) begin
      errs++; $display("FAIL R13 oe_n high: got %h expected 00", got);
    end
    oe_n = 0; ce_n = 1;
    #1 got = rdata;
    checks++;
    if (got !== 8'h00) begin
      errs++; $display("FAIL R13 ce_n high: got %h expected 00", got);
    end
    oe_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_clock_carries;
    t_year_end;
    t_month_lengths;
    t_stop;
    t_divider;
    t_read_freeze;
    t_ignored_and_misc;
    t_read_gate;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule